// File: doc/BRIEF.md
# Ring Gateway Transfer Sequencer

This block is the control unit that sits beside a group of cascaded bus-controller cells sharing a wide ring bus. A transfer request names one source cell, a message slot in that cell's message memory and a bit mask of destination cells. The sequencer first commands the source cell to fetch the slot into its interface register. It then has the source drive that register onto the ring while every chosen destination latches it in the same clock cycle. Last, it commands every destination to store the message and start sending it. One destination or all of them takes the same four cycles.

A processor keeps direct access to the cells throughout. Each cycle it signals which cells it is using. If a cell that the current step needs is among them, the processor wins. The sequencer then drives no strobe and holds its step until that cell is released. Cells the step does not touch never cause a stall. A request whose mask names no cell other than the source is refused with a one-cycle error pulse.

Top module: `gw_xfer_seq`

## Requirements
- R1: After reset every output is low: busy, done, err, all per-cell lines, and slot_out is zero.
- R2: An accepted request in idle makes busy rise on the next cycle. Then follows a fetch step of two unstalled cycles, in which cmd_req is high for the source cell only and cmd_mask is low everywhere.
- R3: After the fetch comes one ring cycle. In it rd_sel is high for the source only, while wr_sel and wr_en are both high for every destination in that same cycle.
- R4: After the ring cycle comes one store cycle, with cmd_req and cmd_mask both high on every destination and low on all other cells. A high cmd_mask means store and transmit. A low cmd_mask means fetch.
- R5: done is high for exactly one cycle, the cycle right after the store cycle, and busy is low in that cycle. With no contention, done comes five cycles after the request cycle.
- R6: A source bit set in the destination mask is dropped, so the source never gets wr_sel, wr_en or a store command.
- R7: A request whose mask is empty, or names only the source, raises err for one cycle on the next cycle. busy stays low and no per-cell line goes high.
- R8: req_valid is ignored while busy is high. The running transfer proceeds unchanged.
- R9: If cpu_sel marks a cell the current step needs, the step drives no cmd_req, cmd_mask, rd_sel, wr_sel or wr_en on any cell. The step is not consumed and resumes once cpu_sel releases the cell. Source is needed by fetch, source and destinations by ring, destinations by store.
- R10: A cpu_sel bit on a cell the current step does not need causes no stall.
- R11: gw_mode is high, while busy, for the source and every destination, except those cells whose cpu_sel bit is high. It is low for all cells while idle.
- R12: slot_out shows the slot of the accepted request and holds it steady for the whole transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request strobe |
| req_src | input | SRC_W | Source cell index |
| req_slot | input | SLOT_W | Message slot in the source cell |
| req_dst | input | N_CELLS | Destination cell mask |
| cpu_sel | input | N_CELLS | Cells the processor is accessing this cycle |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |
| slot_out | output | SLOT_W | Slot number presented to the source cell |
| gw_mode | output | N_CELLS | Per-cell gateway mode (ring path selected) |
| wr_en | output | N_CELLS | Per-cell interface register write enable |
| cmd_req | output | N_CELLS | Per-cell memory command request |
| cmd_mask | output | N_CELLS | Per-cell command direction (1 = store and transmit) |
| wr_sel | output | N_CELLS | Per-cell load from ring select |
| rd_sel | output | N_CELLS | Per-cell drive onto ring select |

## Verification
Some properties are checked on every cycle. No strobe ever reaches a cell the processor holds. A cell never drives and loads the ring at once. cmd_mask never appears without cmd_req. done and err are single pulses that never overlap, and the slot stays steady while busy. Other behaviour only the bench scenarios can show. That includes the exact step order and length, dropping the source from the mask, and rejecting empty masks. It also includes ignoring requests while busy, and resuming after a stall without losing a fetch cycle. For these the reference model is compared against every output on every clock.

// File: rtl/gw_xfer_pkg.sv
package gw_xfer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_RING  = 2'd2,
        ST_STORE = 2'd3
    } gw_step_e;
endpackage

// File: rtl/gw_req_check.sv
module gw_req_check #(
    parameter int N_CELLS = 4,
    parameter int SRC_W   = 2
) (
    input  logic [SRC_W-1:0]   src,
    input  logic [N_CELLS-1:0] dst,
    output logic [N_CELLS-1:0] eff_dst,
    output logic               ok
);
    logic [N_CELLS-1:0] src_bit;
    logic               src_in_range;

    always_comb begin
        src_bit      = '0;
        src_in_range = 1'b0;
        for (int i = 0; i < N_CELLS; i++) begin
            if (SRC_W'(i) == src) begin
                src_bit[i]   = 1'b1;
                src_in_range = 1'b1;
            end
        end
        // the source is never its own destination
        eff_dst = dst & ~src_bit;
        ok      = src_in_range && (|eff_dst);
    end
endmodule

// File: rtl/gw_cell_drive.sv
module gw_cell_drive #(
    parameter int N_CELLS = 4
) (
    input  logic               active,
    input  logic               ph_fetch,
    input  logic               ph_ring,
    input  logic               ph_store,
    input  logic               stall,
    input  logic [N_CELLS-1:0] src_hot,
    input  logic [N_CELLS-1:0] dst,
    input  logic [N_CELLS-1:0] cpu_sel,
    output logic [N_CELLS-1:0] gw_mode,
    output logic [N_CELLS-1:0] wr_en,
    output logic [N_CELLS-1:0] cmd_req,
    output logic [N_CELLS-1:0] cmd_mask,
    output logic [N_CELLS-1:0] wr_sel,
    output logic [N_CELLS-1:0] rd_sel
);
    logic go;
    assign go = ~stall;

    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
        logic involved;
        assign involved    = src_hot[i] | dst[i];
        assign gw_mode[i]  = active & involved & ~cpu_sel[i];
        assign cmd_req[i]  = go & ((ph_fetch & src_hot[i]) | (ph_store & dst[i]));
        assign cmd_mask[i] = go & ph_store & dst[i];
        assign rd_sel[i]   = go & ph_ring & src_hot[i];
        assign wr_sel[i]   = go & ph_ring & dst[i];
        assign wr_en[i]    = go & ph_ring & dst[i];
    end
endmodule

// File: rtl/gw_xfer_seq.sv
module gw_xfer_seq
    import gw_xfer_pkg::*;
#(
    parameter int N_CELLS = 4,
    parameter int SLOT_W  = 5,
    localparam int SRC_W  = (N_CELLS > 1) ? $clog2(N_CELLS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [SRC_W-1:0]   req_src,
    input  logic [SLOT_W-1:0]  req_slot,
    input  logic [N_CELLS-1:0] req_dst,
    input  logic [N_CELLS-1:0] cpu_sel,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [SLOT_W-1:0]  slot_out,
    output logic [N_CELLS-1:0] gw_mode,
    output logic [N_CELLS-1:0] wr_en,
    output logic [N_CELLS-1:0] cmd_req,
    output logic [N_CELLS-1:0] cmd_mask,
    output logic [N_CELLS-1:0] wr_sel,
    output logic [N_CELLS-1:0] rd_sel
);
    localparam logic [N_CELLS-1:0] ONE_HOT0 = N_CELLS'(1);

    typedef struct packed {
        gw_step_e           step;
        logic               half;
        logic [SRC_W-1:0]   src;
        logic [SLOT_W-1:0]  slot;
        logic [N_CELLS-1:0] dst;
        logic               done;
        logic               err;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [N_CELLS-1:0] eff_dst;
    logic               req_ok;
    logic [N_CELLS-1:0] src_hot;
    logic [N_CELLS-1:0] need;
    logic               stall;
    logic               ph_fetch, ph_ring, ph_store, active;

    gw_req_check #(.N_CELLS(N_CELLS), .SRC_W(SRC_W)) u_chk (
        .src     (req_src),
        .dst     (req_dst),
        .eff_dst (eff_dst),
        .ok      (req_ok)
    );

    always_comb begin
        src_hot  = ONE_HOT0 << c_q.src;
        ph_fetch = (c_q.step == ST_FETCH);
        ph_ring  = (c_q.step == ST_RING);
        ph_store = (c_q.step == ST_STORE);
        active   = (c_q.step != ST_IDLE);
        need     = ({N_CELLS{ph_fetch}} & src_hot)
                 | ({N_CELLS{ph_ring}}  & (src_hot | c_q.dst))
                 | ({N_CELLS{ph_store}} & c_q.dst);
        stall    = |(need & cpu_sel);
    end

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        c_d.err  = 1'b0;
        unique case (c_q.step)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_ok) begin
                        c_d.step = ST_FETCH;
                        c_d.half = 1'b0;
                        c_d.src  = req_src;
                        c_d.slot = req_slot;
                        c_d.dst  = eff_dst;
                    end else begin
                        c_d.err = 1'b1;
                    end
                end
            end
            ST_FETCH: begin
                if (!stall) begin
                    if (c_q.half) c_d.step = ST_RING;
                    else          c_d.half = 1'b1;
                end
            end
            ST_RING: begin
                if (!stall) c_d.step = ST_STORE;
            end
            ST_STORE: begin
                if (!stall) begin
                    c_d.step = ST_IDLE;
                    c_d.done = 1'b1;
                end
            end
            default: c_d.step = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    gw_cell_drive #(.N_CELLS(N_CELLS)) u_drv (
        .active   (active),
        .ph_fetch (ph_fetch),
        .ph_ring  (ph_ring),
        .ph_store (ph_store),
        .stall    (stall),
        .src_hot  (src_hot),
        .dst      (c_q.dst),
        .cpu_sel  (cpu_sel),
        .gw_mode  (gw_mode),
        .wr_en    (wr_en),
        .cmd_req  (cmd_req),
        .cmd_mask (cmd_mask),
        .wr_sel   (wr_sel),
        .rd_sel   (rd_sel)
    );

    assign busy     = active;
    assign done     = c_q.done;
    assign err      = c_q.err;
    assign slot_out = c_q.slot;

    // R9
    cpu_owns_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_req | cmd_mask | wr_en | wr_sel | rd_sel) & cpu_sel) == '0);

    // R6
    ring_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel & wr_sel) == '0);

    // R3
    ring_single_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_sel));

    // R4
    mask_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_mask & ~cmd_req) == '0);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && !done));

    // R12
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(slot_out));
endmodule

// File: tb/sim_gw_xfer_seq.sv
`timescale 1ns/1ps
module sim_gw_xfer_seq;
    localparam int N     = 4;
    localparam int SW    = 2;
    localparam int SLW   = 5;
    localparam int NMASK = (1 << N) - 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic [SW-1:0]  req_src = '0;
    logic [SLW-1:0] req_slot = '0;
    logic [N-1:0]   req_dst = '0;
    logic [N-1:0]   cpu_sel = '0;
    logic           busy, done, err;
    logic [SLW-1:0] slot_out;
    logic [N-1:0]   gw_mode, wr_en, cmd_req, cmd_mask, wr_sel, rd_sel;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    // reference model state: step 0 idle, 1 fetch, 2 ring, 3 store
    int ms = 0, mc = 0, msrc = 0, mslot = 0, mdst = 0, mdone = 0, merr = 0;

    always #10 clk = ~clk;

    gw_xfer_seq #(.N_CELLS(N), .SLOT_W(SLW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
        .req_slot(req_slot), .req_dst(req_dst), .cpu_sel(cpu_sel),
        .busy(busy), .done(done), .err(err), .slot_out(slot_out),
        .gw_mode(gw_mode), .wr_en(wr_en), .cmd_req(cmd_req), .cmd_mask(cmd_mask),
        .wr_sel(wr_sel), .rd_sel(rd_sel)
    );

    task automatic chk(input string sc, input string fld, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h", sc, fld, act, exp);
        end
    endtask

    task automatic cyc(input string sc, input bit rv, input int src, input int slot,
                       input int dst, input int cpu);
        int need, stall, inv, srcb, e_gw, e_cr, e_cm, e_rd, e_ws;
        int nd, ne, eff;
        @(negedge clk);
        req_valid = rv;
        req_src   = SW'(src);
        req_slot  = SLW'(slot);
        req_dst   = N'(dst);
        cpu_sel   = N'(cpu);
        #1;
        srcb = 1 << msrc;
        need = (ms == 1) ? srcb : (ms == 2) ? (srcb | mdst) : (ms == 3) ? mdst : 0;
        stall = ((need & cpu) != 0);
        inv  = srcb | mdst;
        e_gw = (ms != 0) ? (inv & ~cpu & NMASK) : 0;
        e_cr = 0; e_cm = 0; e_rd = 0; e_ws = 0;
        if (!stall) begin
            if (ms == 1) e_cr = srcb;
            if (ms == 2) begin e_rd = srcb; e_ws = mdst; end
            if (ms == 3) begin e_cr = mdst; e_cm = mdst; end
        end
        chk(sc, "R8 busy",     int'(busy),     (ms != 0) ? 1 : 0);
        chk(sc, "R5 done",     int'(done),     mdone);
        chk(sc, "R7 err",      int'(err),      merr);
        chk(sc, "R12 slot",    int'(slot_out), mslot);
        chk(sc, "R11 gw_mode", int'(gw_mode),  e_gw);
        chk(sc, "R2 cmd_req",  int'(cmd_req),  e_cr);
        chk(sc, "R4 cmd_mask", int'(cmd_mask), e_cm);
        chk(sc, "R3 rd_sel",   int'(rd_sel),   e_rd);
        chk(sc, "R3 wr_sel",   int'(wr_sel),   e_ws);
        chk(sc, "R3 wr_en",    int'(wr_en),    e_ws);
        nd = 0; ne = 0;
        case (ms)
            0: if (rv) begin
                   eff = dst & ~(1 << src) & NMASK;
                   if (eff != 0) begin
                       ms = 1; mc = 0; msrc = src; mslot = slot; mdst = eff;
                   end else ne = 1;
               end
            1: if (!stall) begin if (mc == 1) ms = 2; else mc = 1; end
            2: if (!stall) ms = 3;
            3: if (!stall) begin ms = 0; nd = 1; end
            default: ms = 0;
        endcase
        mdone = nd; merr = ne;
        @(posedge clk);
    endtask

    task automatic idle(input string sc, input int n);
        for (int k = 0; k < n; k++) cyc(sc, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: outputs after reset
        idle("R1", 2);

        // R2 R3 R4 R5: plain transfer source 1, slot 7, to cells 2 and 3
        cyc("R2", 1, 1, 7, 'b1100, 0);
        idle("R5", 6);

        // R6: broadcast mask including the source
        cyc("R6", 1, 2, 19, 'b1111, 0);
        idle("R6", 6);

        // R7: empty mask, then source-only mask
        cyc("R7", 1, 0, 3, 'b0000, 0);
        idle("R7", 2);
        cyc("R7", 1, 3, 4, 'b1000, 0);
        idle("R7", 2);

        // R8: new requests while busy are ignored
        cyc("R8", 1, 0, 9, 'b0010, 0);
        cyc("R8", 1, 3, 30, 'b0101, 0);
        cyc("R8", 1, 2, 1, 'b0001, 0);
        idle("R8", 5);

        // R9: processor holds source during fetch, then a destination in ring and store
        cyc("R9", 1, 1, 12, 'b0101, 0);
        cyc("R9", 0, 0, 0, 0, 'b0010);
        cyc("R9", 0, 0, 0, 0, 0);
        cyc("R9", 0, 0, 0, 0, 'b0010);
        cyc("R9", 0, 0, 0, 0, 0);
        cyc("R9", 0, 0, 0, 0, 'b0100);
        cyc("R9", 0, 0, 0, 0, 'b0100);
        cyc("R9", 0, 0, 0, 0, 0);
        cyc("R9", 0, 0, 0, 0, 'b0001);
        cyc("R9", 0, 0, 0, 0, 0);
        idle("R9", 3);

        // R10: processor on a cell outside the transfer
        cyc("R10", 1, 0, 21, 'b0100, 'b1000);
        for (int k = 0; k < 6; k++) cyc("R10", 0, 0, 0, 0, 'b1010);
        idle("R10", 2);

        // R11 R12: all destinations, processor flicking over cells
        cyc("R11", 1, 3, 31, 'b0111, 0);
        for (int k = 0; k < 10; k++) cyc("R11", 0, 0, 0, 0, (k % 3 == 0) ? 'b0001 : 0);
        idle("R12", 3);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule